// File: doc/BRIEF.md
# Display Controller Run Control and Status Core

This block holds the run state of a display controller and the status bits that software sees. Software starts the controller by writing the enable bit of the control register. It can then stop it in one of two ways. A graceful stop sets the disable bit: the current frame is fetched to its end, no further frame is started, and once the last pixel has left the pins the hardware sets a done flag and clears the enable bit by itself. An abrupt stop writes the enable bit to zero: pin driving is released on the next clock and a quick-stop flag is raised.

The fetch and timing datapath reports events to this core as single-cycle pulses: start of frame, end of frame, output FIFO underflow, input FIFO underflow, bus error and last pixel sent. Each event sets a sticky flag. Software clears a flag by writing 1 to it. Each flag has a mask bit, and the interrupt line is raised while any flag is set and unmasked. A bus error also holds the DMA engine halted until software writes a new frame descriptor address.

Top module: `lcd_ctl_core`

## Requirements
- R1: After reset, run and pin_en are 0, halt_dma is 1, irq is 0, all status flags are 0, and every mask bit is 1, so the control register reads 0x00007F00.
- R2: Register map: control at address 0, status at address 1, descriptor address at address 2; any other read address returns 0. In the control register, bit 0 is enable, bit 1 is disable and bits 14:8 are the mask bits. A control write with bit 0 set while stopped raises run and pin_en on the next cycle. halt_dma is 1 whenever run is 0 or a bus error is pending.
- R3: Graceful stop: while running with the disable bit set, an end-of-frame pulse drops run (pin_en stays 1). The following last-pixel pulse sets the done flag (status bit 5), drops pin_en, and clears the enable and disable bits in the control register. If that pulse comes in the same cycle as a control write with enable set, the end of the stop wins.
- R4: Quick stop: a control write with bit 0 clear while pin_en is 1 drops run and pin_en on the next cycle and sets the quick-stop flag (status bit 6). The same write while stopped sets no flag.
- R5: The event pulses set sticky flags: start of frame sets bit 0, end of frame bit 1, output FIFO underflow bit 2, input FIFO underflow bit 3 and bus error bit 4. Hardware never clears a flag.
- R6: Writing the status register clears every flag whose data bit is 1 and leaves the others unchanged. A hardware set in the same cycle wins over the clear.
- R7: Mask bit 8+i belongs to flag i. irq is 1 exactly when some flag is 1 while its mask bit is 0, in the same cycle the flag becomes visible.
- R8: While pin_en is 1, control writes leave the mask bits unchanged; only the enable and disable bits take effect.
- R9: A bus error pulse forces halt_dma to 1 from the next cycle until the cycle after a write to the descriptor address register, which reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data, combinational from rd_addr |
| ev_sof | input | 1 | Start-of-frame event pulse |
| ev_eof | input | 1 | End-of-frame (fetch complete) event pulse |
| ev_out_unf | input | 1 | Output FIFO underflow pulse |
| ev_in_unf | input | 1 | Input FIFO underflow pulse |
| ev_bus_err | input | 1 | DMA bus error pulse |
| ev_last_px | input | 1 | Last pixel of the frame sent to the pins |
| run | output | 1 | Controller may fetch new frames |
| pin_en | output | 1 | Display pins are driven |
| halt_dma | output | 1 | DMA engine must hold |
| irq | output | 1 | Combined interrupt request |

## Verification
The bound checker covers the behaviours that hold from one cycle to the next. After a quick-stop write or a last-pixel pulse in the final stop phase, the pins are released. No flag falls without a status write. The mask bits stay fixed during a control write while the pins are driven. A bus error halts the DMA, and irq stays low when no flag is set. The complete stop sequences can only be seen in the bench's scenarios: the graceful stop that waits for the end of frame and then the last pixel, a restart after either kind of stop, the readback of the enable and disable bits, and the release of the halt by a descriptor write.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;
  localparam int NFLAG    = 7;
  localparam int F_SOF    = 0;
  localparam int F_EOF    = 1;
  localparam int F_OUNF   = 2;
  localparam int F_IUNF   = 3;
  localparam int F_BERR   = 4;
  localparam int F_DONE   = 5;
  localparam int F_QUICK  = 6;
  localparam int CTL_EN   = 0;
  localparam int CTL_STOP = 1;
  localparam int MASK_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } run_st_t;
endpackage

// File: rtl/lcd_ctl_seq.sv
module lcd_ctl_seq
  import lcd_ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctl_wr,
  input  logic    wr_en_bit,
  input  logic    wr_stop_bit,
  input  logic    ev_eof,
  input  logic    ev_last_px,
  output run_st_t st_o,
  output logic    stop_o,
  output logic    quick_o,
  output logic    done_o
);
  run_st_t st_q, st_d;
  logic    stop_q, stop_d;
  logic    quick, done;

  // abrupt stop only counts when the pins are driven
  assign quick = ctl_wr && !wr_en_bit && (st_q != ST_IDLE);
  assign done  = !quick && (st_q == ST_FLUSH) && ev_last_px;

  always_comb begin
    st_d = st_q;
    if (quick) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  if (ctl_wr && wr_en_bit) st_d = ST_RUN;
        ST_RUN:   if (stop_q && ev_eof)    st_d = ST_FLUSH;
        ST_FLUSH: if (ev_last_px)          st_d = ST_IDLE;
        default:                           st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stop_d = stop_q;
    if (quick || done)  stop_d = 1'b0;
    else if (ctl_wr)    stop_d = wr_en_bit && wr_stop_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stop_q <= stop_d;
    end
  end

  assign st_o    = st_q;
  assign stop_o  = stop_q;
  assign quick_o = quick;
  assign done_o  = done;
endmodule

// File: rtl/lcd_ctl_flags.sv
module lcd_ctl_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q, f_d;
    always_comb begin
      f_d = f_q;
      if (set_i[i])      f_d = 1'b1;
      else if (clr_i[i]) f_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= f_d;
    end
    assign flags_o[i] = f_q;
  end
endmodule

// File: rtl/lcd_ctl_irq.sv
module lcd_ctl_irq #(
  parameter int N = 7
) (
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic [N-1:0] pend;
  assign pend  = flags_i & ~mask_i;
  assign irq_o = |pend;
endmodule

// File: rtl/lcd_ctl_core.sv
module lcd_ctl_core
  import lcd_ctl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int REG_CTL  = 0,
  parameter int REG_STAT = 1,
  parameter int REG_DESC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_sof,
  input  logic              ev_eof,
  input  logic              ev_out_unf,
  input  logic              ev_in_unf,
  input  logic              ev_bus_err,
  input  logic              ev_last_px,
  output logic              run,
  output logic              pin_en,
  output logic              halt_dma,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(REG_CTL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_DESC = ADDR_W'(REG_DESC);

  logic              ctl_wr, stat_wr, desc_wr;
  run_st_t           st;
  logic              stop_bit, quick_ev, done_ev;
  logic [NFLAG-1:0]  flag_set, flag_clr, flags_q;
  logic [NFLAG-1:0]  mask_q, mask_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] desc_q, desc_d;
  logic [DATA_W-1:0] ctl_rd;

  assign ctl_wr  = wr_en && (wr_addr == A_CTL);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign desc_wr = wr_en && (wr_addr == A_DESC);

  lcd_ctl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .wr_en_bit   (wr_data[CTL_EN]),
    .wr_stop_bit (wr_data[CTL_STOP]),
    .ev_eof      (ev_eof),
    .ev_last_px  (ev_last_px),
    .st_o        (st),
    .stop_o      (stop_bit),
    .quick_o     (quick_ev),
    .done_o      (done_ev)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[F_SOF]   = ev_sof;
    flag_set[F_EOF]   = ev_eof;
    flag_set[F_OUNF]  = ev_out_unf;
    flag_set[F_IUNF]  = ev_in_unf;
    flag_set[F_BERR]  = ev_bus_err;
    flag_set[F_DONE]  = done_ev;
    flag_set[F_QUICK] = quick_ev;
  end
  assign flag_clr = stat_wr ? wr_data[NFLAG-1:0] : '0;

  lcd_ctl_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags_q)
  );

  lcd_ctl_irq #(.N(NFLAG)) u_irq (
    .flags_i (flags_q),
    .mask_i  (mask_q),
    .irq_o   (irq)
  );

  // masks are configuration: writable only while stopped
  always_comb begin
    mask_d = mask_q;
    if (ctl_wr && (st == ST_IDLE)) mask_d = wr_data[MASK_LSB +: NFLAG];
  end

  always_comb begin
    err_d = err_q;
    if (ev_bus_err)   err_d = 1'b1;
    else if (desc_wr) err_d = 1'b0;
  end

  always_comb begin
    desc_d = desc_q;
    if (desc_wr) desc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      err_q  <= 1'b0;
      desc_q <= '0;
    end else begin
      mask_q <= mask_d;
      err_q  <= err_d;
      desc_q <= desc_d;
    end
  end

  assign run      = (st == ST_RUN);
  assign pin_en   = (st != ST_IDLE);
  assign halt_dma = err_q || !run;

  always_comb begin
    ctl_rd                     = '0;
    ctl_rd[CTL_EN]             = pin_en;
    ctl_rd[CTL_STOP]           = stop_bit;
    ctl_rd[MASK_LSB +: NFLAG]  = mask_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTL)       rd_data = ctl_rd;
    else if (rd_addr == A_STAT) rd_data = DATA_W'(flags_q);
    else if (rd_addr == A_DESC) rd_data = desc_q;
  end
endmodule

// File: rtl/lcd_ctl_core_chk.sv
module lcd_ctl_core_chk
  import lcd_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             stat_wr,
  input logic             wr_en_bit,
  input run_st_t          st,
  input logic             ev_last_px,
  input logic             ev_bus_err,
  input logic [NFLAG-1:0] flags_q,
  input logic [NFLAG-1:0] mask_q,
  input logic             pin_en,
  input logic             halt_dma,
  input logic             irq
);
  AST_QUICK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wr_en_bit && pin_en) |=> (!pin_en && flags_q[F_QUICK])); // R4

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FLUSH) && ev_last_px) |=> (!pin_en && (flags_q[F_DONE] || flags_q[F_QUICK]))); // R3

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && pin_en) |=> $stable(mask_q)); // R8

  AST_BUS_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> halt_dma); // R9

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> !irq); // R7

  AST_FLUSH_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLUSH) |-> (halt_dma && pin_en)); // R3
endmodule

bind lcd_ctl_core lcd_ctl_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .stat_wr    (stat_wr),
  .wr_en_bit  (wr_data[0]),
  .st         (st),
  .ev_last_px (ev_last_px),
  .ev_bus_err (ev_bus_err),
  .flags_q    (flags_q),
  .mask_q     (mask_q),
  .pin_en     (pin_en),
  .halt_dma   (halt_dma),
  .irq        (irq)
);

// File: tb/test_lcd_ctl_core.sv
`timescale 1ns/1ps
module test_lcd_ctl_core;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic ev_sof = 1'b0, ev_eof = 1'b0, ev_out_unf = 1'b0, ev_in_unf = 1'b0;
  logic ev_bus_err = 1'b0, ev_last_px = 1'b0;
  logic run, pin_en, halt_dma, irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // bench model state (0 stopped, 1 running, 2 final frame)
  int       m_st = 0;
  bit       m_stop = 1'b0;
  bit [6:0] m_mask = 7'h7F;
  bit [6:0] m_flag = 7'h00;
  bit       m_err = 1'b0;
  bit [31:0] m_desc = 32'h0;

  always #5 clk = ~clk;

  lcd_ctl_core i_lcd_ctl_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_sof(ev_sof), .ev_eof(ev_eof),
    .ev_out_unf(ev_out_unf), .ev_in_unf(ev_in_unf), .ev_bus_err(ev_bus_err),
    .ev_last_px(ev_last_px), .run(run), .pin_en(pin_en), .halt_dma(halt_dma), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_read(input int a);
    bit [31:0] v = 32'h0;
    case (a)
      0: begin v[0] = (m_st != 0); v[1] = m_stop; v[14:8] = m_mask; end
      1: v[6:0] = m_flag;
      2: v = m_desc;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  task automatic model_upd();
    bit ctlw, quick, done;
    bit [6:0] set, clr;
    ctlw  = wr_en && (wr_addr == 0);
    quick = ctlw && !wr_data[0] && (m_st != 0);
    done  = !quick && (m_st == 2) && ev_last_px;
    set = {quick, done, ev_bus_err, ev_in_unf, ev_out_unf, ev_eof, ev_sof};
    clr = (wr_en && wr_addr == 1) ? wr_data[6:0] : 7'h0;
    if (ctlw && m_st == 0) m_mask = wr_data[14:8];
    if (quick || done) m_stop = 1'b0;
    else if (ctlw) m_stop = wr_data[0] && wr_data[1];
    if (quick) m_st = 0;
    else if (m_st == 0 && ctlw && wr_data[0]) m_st = 1;
    else if (m_st == 1 && ev_eof && m_stop_prev) m_st = 2;
    else if (m_st == 2 && ev_last_px) m_st = 0;
    m_flag = (m_flag & ~clr) | set;
    if (ev_bus_err) m_err = 1'b1;
    else if (wr_en && wr_addr == 2) m_err = 1'b0;
    if (wr_en && wr_addr == 2) m_desc = wr_data;
  endtask

  bit m_stop_prev = 1'b0;

  task automatic compare();
    chk("R2 run", {31'b0, run}, {31'b0, m_st == 1});
    chk("R3/R4 pin_en", {31'b0, pin_en}, {31'b0, m_st != 0});
    chk("R9 halt_dma", {31'b0, halt_dma}, {31'b0, m_err || (m_st != 1)});
    chk("R7 irq", {31'b0, irq}, {31'b0, |(m_flag & ~m_mask)});
    chk("R5/R6 rd_data", rd_data, exp_read(int'(rd_addr)));
  endtask

  task automatic clear_in();
    wr_en = 1'b0; ev_sof = 1'b0; ev_eof = 1'b0; ev_out_unf = 1'b0;
    ev_in_unf = 1'b0; ev_bus_err = 1'b0; ev_last_px = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    m_stop_prev = m_stop;
    model_upd();
    @(negedge clk);
    clear_in();
    #1;
    compare();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    step();
  endtask

  task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    compare();
    rd_chk("R1 control after reset", 0, 32'h0000_7F00);
    rd_chk("R1 status after reset", 1, 32'h0);
    chk("R1 halt after reset", {31'b0, halt_dma}, 32'h1);

    // R2 start with all interrupts unmasked
    wr(0, 32'h0000_0001);
    chk("R2 run after enable", {31'b0, run}, 32'h1);
    chk("R2 halt released", {31'b0, halt_dma}, 32'h0);

    // R5 / R7 start of frame sets bit 0 and irq
    ev_sof = 1'b1; step();
    rd_chk("R5 sof flag", 1, 32'h1);
    chk("R7 irq on unmasked flag", {31'b0, irq}, 32'h1);

    // R6 clear while a new set arrives on another bit, then set beats clear
    ev_out_unf = 1'b1; wr(1, 32'h0000_0001);
    rd_chk("R6 w1c clears only bit 0", 1, 32'h4);
    ev_out_unf = 1'b1; wr(1, 32'h0000_0004);
    rd_chk("R6 set wins over clear", 1, 32'h4);
    wr(1, 32'h7F);
    rd_chk("R6 all cleared", 1, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq}, 32'h0);

    // R8 mask write ignored while running
    wr(0, 32'h0000_7F01);
    rd_chk("R8 masks unchanged while running", 0, 32'h0000_0001);

    // R3 graceful stop
    wr(0, 32'h0000_0003);
    rd_chk("R3 disable bit visible", 0, 32'h0000_0003);
    ev_eof = 1'b1; step();
    chk("R3 run drops after final eof", {31'b0, run}, 32'h0);
    chk("R3 pins still driven", {31'b0, pin_en}, 32'h1);
    chk("R3 dma halted in final frame", {31'b0, halt_dma}, 32'h1);
    step();
    chk("R3 pins held until last pixel", {31'b0, pin_en}, 32'h1);
    ev_last_px = 1'b1; step();
    chk("R3 pins released", {31'b0, pin_en}, 32'h0);
    rd_chk("R3 done flag bit 5", 1, 32'h0000_0022);
    rd_chk("R3 enable and disable cleared", 0, 32'h0);
    wr(1, 32'h7F);

    // R4 quick stop
    wr(0, 32'h0000_0001);
    wr(0, 32'h0000_0000);
    chk("R4 pins released at once", {31'b0, pin_en}, 32'h0);
    rd_chk("R4 quick flag bit 6", 1, 32'h0000_0040);
    wr(1, 32'h7F);
    wr(0, 32'h0000_0000);
    rd_chk("R4 no quick flag when stopped", 1, 32'h0);

    // R9 bus error halts dma until descriptor write
    wr(0, 32'h0000_0001);
    ev_bus_err = 1'b1; step();
    chk("R9 halt on bus error", {31'b0, halt_dma}, 32'h1);
    rd_chk("R5 bus error flag bit 4", 1, 32'h10);
    step();
    chk("R9 halt persists", {31'b0, halt_dma}, 32'h1);
    wr(2, 32'hCAFE_0040);
    chk("R9 halt released by descriptor", {31'b0, halt_dma}, 32'h0);
    rd_chk("R9 descriptor readback", 2, 32'hCAFE_0040);
    wr(0, 32'h0);
    wr(1, 32'h7F);

    // R2 unmapped address reads zero
    rd_chk("R2 unmapped read", 5, 32'h0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      ev_sof     = ($urandom % 16) == 0;
      ev_eof     = ($urandom % 10) == 0;
      ev_out_unf = ($urandom % 24) == 0;
      ev_in_unf  = ($urandom % 24) == 0;
      ev_bus_err = ($urandom % 40) == 0;
      ev_last_px = ($urandom % 6) == 0;
      rd_addr    = AW'($urandom % 4);
      if (($urandom % 5) == 0) begin
        wr_en   = 1'b1;
        wr_addr = AW'($urandom % 3);
        wr_data = $urandom;
        if (wr_addr == 0) begin
          wr_data[0] = ($urandom % 6) != 0;
          wr_data[1] = ($urandom % 3) == 0;
        end
      end
      step();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule